// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Image Loader and Word Writer

This block is the master side of a three-wire serial EEPROM link to a 64-word by 16-bit device. It drives chip select, the serial clock and the serial data line toward the memory, and it samples the data line coming back. The serial clock comes from the system clock through a parameterised divider.

A load command reads every word of the device in ascending address order. Each word is stored as a pair of bytes in an internal image, so nearby logic can fetch identifiers or a station address by byte index through a read port. A write command sends one 16-bit word to one address. The controller always issues a write-enable frame first, with no extra request from the host. The `busy` output is high while a command runs, and `done` marks the cycle in which the command finishes.

Top module: `uw_eeprom_ctrl`

## Requirements
- R1: While `rst_n` is low, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are all 0.
- R2: Every frame starts with these bits in this order: a 0, then a 1, then a 2-bit opcode, then a 6-bit address sent most significant bit first. Read uses opcode 2'b10 and write uses opcode 2'b01.
- R3: In a read frame, 16 data bits follow the address. They arrive most significant bit first, one bit per serial clock period.
- R4: A load runs exactly 64 read frames, for addresses 0 through 63 in ascending order, and `ee_cs` goes low between frames.
- R5: The word read from address a is stored with its low byte at image index 2a and its high byte at index 2a+1. `img_byte` shows the byte selected by `img_idx`.
- R6: A write sends two frames. The first is a write-enable frame: opcode 2'b00 and an address field whose two top bits are 11, with no data. The second is the write frame, carrying the 16 data bits most significant bit first.
- R7: One serial clock period lasts 2*CLK_DIV system clocks. `ee_di` changes only when `ee_sk` falls, and `ee_do` is sampled when `ee_sk` rises.
- R8: Between frames, `ee_cs` stays low for at least 2*CLK_DIV system clocks. `ee_sk` is low whenever `ee_cs` is low.
- R9: `busy` rises on the clock after a start is accepted. `done` is a one-cycle pulse that appears in the cycle `busy` falls.
- R10: A start request that arrives while `busy` is high is ignored.
- R11: A completed write also updates the two bytes of that word in the internal image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_start | input | 1 | Starts a full image load; takes priority over a write start in the same cycle |
| wr_start | input | 1 | Starts a single-word write |
| wr_addr | input | 6 | Word address for the write |
| wr_data | input | 16 | Data word for the write |
| busy | output | 1 | High while a command is running |
| done | output | 1 | One-cycle pulse when a command completes |
| img_idx | input | 7 | Byte index into the stored image |
| img_byte | output | 8 | Image byte at `img_idx` |
| ee_cs | output | 1 | Chip select toward the EEPROM |
| ee_sk | output | 1 | Serial clock toward the EEPROM |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The assertions check on every cycle the rules that can be seen on the pins at any moment:
- the serial clock stays quiet while chip select is low;
- the data line holds steady while the serial clock is high;
- chip select rises only after a long enough low gap;
- chip select is never active outside `busy`;
- `done` is a single-cycle pulse that ends `busy`.

Only the bench's scenarios can show the rest, because it needs a model of the memory. That covers the bit order inside each frame, the ascending address walk, the byte placement in the image, the write-enable frame ahead of every write, and the fact that a start request during a command has no effect.

// File: rtl/uw_pkg.sv
package uw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } uw_state_e;

   typedef enum logic {
      MD_LOAD  = 1'b0,
      MD_WRITE = 1'b1
   } uw_mode_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_WREN  = 2'b00;
endpackage

// File: rtl/uw_bit_timer.sv
module uw_bit_timer #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic rise_next,
   output logic slot_end,
   output logic sk_hi
);
   localparam int PH_W    = (2 * CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
   localparam int HALF    = CLK_DIV;
   localparam int LAST_PH = 2 * CLK_DIV - 1;

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (!run || ph_q == PH_W'(LAST_PH)) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign rise_next = run && (ph_q == PH_W'(HALF - 1));
   assign slot_end  = run && (ph_q == PH_W'(LAST_PH));
   assign sk_hi     = (ph_q >= PH_W'(HALF));
endmodule

// File: rtl/uw_tx_frame.sv
module uw_tx_frame #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              shift,
   output logic              msb
);
   localparam int FRM = 4 + ADDR_W + DATA_W;

   logic [FRM-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= {1'b0, 1'b1, op, addr, data};
      end else if (shift) begin
         sr_q <= {sr_q[FRM-2:0], 1'b0};
      end
   end

   assign msb = sr_q[FRM-1];
endmodule

// File: rtl/uw_image.sv
module uw_image #(
   parameter int ADDR_W   = 6,
   parameter int REG_READ = 0
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [15:0]       wword,
   input  logic [ADDR_W:0]   ridx,
   output logic [7:0]        rbyte
);
   localparam int NBYTES = 2 << ADDR_W;

   logic [7:0] bytes_q [NBYTES];

   always_ff @(posedge clk) begin
      if (we) begin
         bytes_q[{waddr, 1'b0}] <= wword[7:0];
         bytes_q[{waddr, 1'b1}] <= wword[15:8];
      end
   end

   generate
      if (REG_READ != 0) begin : g_reg_rd
         logic [7:0] rd_q;
         always_ff @(posedge clk) rd_q <= bytes_q[ridx];
         assign rbyte = rd_q;
      end else begin : g_comb_rd
         assign rbyte = bytes_q[ridx];
      end
   endgenerate
endmodule

// File: rtl/uw_eeprom_ctrl.sv
module uw_eeprom_ctrl #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 16,
   parameter int CLK_DIV  = 2,
   parameter int REG_READ = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_start,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   input  logic [ADDR_W:0]   img_idx,
   output logic [7:0]        img_byte,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);
   import uw_pkg::*;

   localparam int HDR_BITS = 4 + ADDR_W;
   localparam int FRM_BITS = HDR_BITS + DATA_W;
   localparam int SLOT_W   = $clog2(FRM_BITS);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
   localparam logic [ADDR_W-1:0] WREN_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("uw_eeprom_ctrl: DATA_W must be 16 for byte-pair packing");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("uw_eeprom_ctrl: ADDR_W must be at least 2");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("uw_eeprom_ctrl: CLK_DIV must be at least 1");
      end
   endgenerate

   uw_state_e         state_q;
   uw_mode_e          mode_q;
   logic              wr_phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rx_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] last_q;
   logic              done_q;

   logic              rise_next, slot_end, sk_hi;
   logic              ld, shift, tx_msb, img_we;
   logic [1:0]        ld_op;
   logic [ADDR_W-1:0] ld_addr;
   logic [DATA_W-1:0] ld_data;
   logic              frame_last;

   uw_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (state_q != ST_IDLE),
      .rise_next (rise_next),
      .slot_end  (slot_end),
      .sk_hi     (sk_hi)
   );

   assign frame_last = (state_q == ST_FRAME) && slot_end && (slot_q == last_q);
   assign shift      = (state_q == ST_FRAME) && slot_end && (slot_q != last_q);

   always_comb begin
      ld      = 1'b0;
      ld_op   = OPC_READ;
      ld_addr = addr_q;
      ld_data = '0;
      case (state_q)
         ST_IDLE: begin
            if (load_start) begin
               ld      = 1'b1;
               ld_addr = '0;
            end else if (wr_start) begin
               ld      = 1'b1;
               ld_op   = OPC_WREN;
               ld_addr = WREN_ADDR;
            end
         end
         ST_GAP: begin
            if (slot_end) begin
               if (mode_q == MD_LOAD && addr_q != LAST_ADDR) begin
                  ld      = 1'b1;
                  ld_addr = ADDR_W'(addr_q + 1);
               end else if (mode_q == MD_WRITE && !wr_phase_q) begin
                  ld      = 1'b1;
                  ld_op   = OPC_WRITE;
                  ld_data = wdata_q;
               end
            end
         end
         default: ;
      endcase
   end

   assign img_we = frame_last && ((mode_q == MD_LOAD) || wr_phase_q);

   uw_tx_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ld),
      .op    (ld_op),
      .addr  (ld_addr),
      .data  (ld_data),
      .shift (shift),
      .msb   (tx_msb)
   );

   uw_image #(.ADDR_W(ADDR_W), .REG_READ(REG_READ)) u_img (
      .clk   (clk),
      .we    (img_we),
      .waddr (addr_q),
      .wword ((mode_q == MD_LOAD) ? rx_q : wdata_q),
      .ridx  (img_idx),
      .rbyte (img_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= MD_LOAD;
         wr_phase_q <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         rx_q       <= '0;
         slot_q     <= '0;
         last_q     <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               slot_q <= '0;
               if (load_start) begin
                  state_q <= ST_FRAME;
                  mode_q  <= MD_LOAD;
                  addr_q  <= '0;
                  last_q  <= SLOT_W'(FRM_BITS - 1);
               end else if (wr_start) begin
                  state_q    <= ST_FRAME;
                  mode_q     <= MD_WRITE;
                  wr_phase_q <= 1'b0;
                  addr_q     <= wr_addr;
                  wdata_q    <= wr_data;
                  last_q     <= SLOT_W'(HDR_BITS - 1);
               end
            end
            ST_FRAME: begin
               if (rise_next && slot_q >= SLOT_W'(HDR_BITS)) begin
                  rx_q <= {rx_q[DATA_W-2:0], ee_do};
               end
               if (slot_end) begin
                  if (slot_q == last_q) state_q <= ST_GAP;
                  else                  slot_q  <= slot_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (slot_end) begin
                  slot_q <= '0;
                  if (mode_q == MD_LOAD && addr_q != LAST_ADDR) begin
                     addr_q  <= ADDR_W'(addr_q + 1);
                     state_q <= ST_FRAME;
                  end else if (mode_q == MD_WRITE && !wr_phase_q) begin
                     wr_phase_q <= 1'b1;
                     last_q     <= SLOT_W'(FRM_BITS - 1);
                     state_q    <= ST_FRAME;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ee_cs = (state_q == ST_FRAME);
   assign ee_sk = (state_q == ST_FRAME) && sk_hi;
   assign ee_di = (state_q == ST_FRAME) && tx_msb;
   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;
endmodule

// File: rtl/uw_eeprom_ctrl_chk.sv
module uw_eeprom_ctrl_chk #(
   parameter int CLK_DIV = 2
) (
   input logic clk,
   input logic rst_n,
   input logic ee_cs,
   input logic ee_sk,
   input logic ee_di,
   input logic busy,
   input logic done
);
   logic [15:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  low_run_q <= 16'hFFFF;
      else if (ee_cs)              low_run_q <= '0;
      else if (low_run_q != 16'hFFFF) low_run_q <= low_run_q + 1'b1;
   end

   AST_SK_QUIET_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs |-> !ee_sk) else $error("sk active without cs"); // R8

   AST_DI_HOLD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && $past(ee_sk)) |-> $stable(ee_di)) else $error("di moved while sk high"); // R7

   AST_CS_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> (low_run_q >= 16'(2 * CLK_DIV))) else $error("cs gap too short"); // R8

   AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs |-> busy) else $error("cs outside busy"); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))) else $error("done not at busy fall"); // R9
endmodule

bind uw_eeprom_ctrl uw_eeprom_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ee_cs (ee_cs),
   .ee_sk (ee_sk),
   .ee_di (ee_di),
   .busy  (busy),
   .done  (done)
);

// File: tb/uw_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module uw_eeprom_ctrl_tb;
   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_start = 1'b0;
   logic        wr_start = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy, done;
   logic [6:0]  img_idx = '0;
   logic [7:0]  img_byte;
   logic        ee_cs, ee_sk, ee_di;
   logic        ee_do = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   uw_eeprom_ctrl #(.CLK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_start(wr_start),
      .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
      .img_idx(img_idx), .img_byte(img_byte),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   function automatic logic [15:0] pat(input logic [5:0] a);
      return {a, 2'b10, a, 2'b01};
   endfunction

   // memory model
   logic [15:0] mem [64];
   bit          primed = 0;
   int          m_n = 0;
   logic [1:0]  m_op = '0;
   logic [5:0]  m_adr = '0;
   logic [15:0] m_wd = '0;
   bit          m_wen = 0;
   logic [5:0]  m_next = '0;
   int m_reads = 0, m_writes = 0, m_wens = 0, m_nowen = 0;
   int m_order_err = 0, m_hdr_err = 0, m_len_err = 0;

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!primed) begin
         for (int a = 0; a < 64; a++) mem[a] = pat(6'(a));
         primed = 1;
      end
      if (!ee_cs) begin
         if (m_n > 0) begin
            if (m_op == 2'b10) begin
               if (m_n == 26) begin
                  m_reads++;
                  if (m_adr != m_next) m_order_err++;
                  m_next = m_adr + 6'd1;
               end else m_len_err++;
            end else if (m_op == 2'b01) begin
               if (m_n == 26) begin
                  m_writes++;
                  if (m_wen) mem[m_adr] = m_wd;
                  else m_nowen++;
                  m_wen = 0;
               end else m_len_err++;
            end else if (m_op == 2'b00 && m_n == 10 && m_adr[5:4] == 2'b11) begin
               m_wen = 1;
               m_wens++;
            end else m_len_err++;
         end
         m_n = 0;
      end else begin
         if (m_n == 0 && ee_di !== 1'b0) m_hdr_err++;
         if (m_n == 1 && ee_di !== 1'b1) m_hdr_err++;
         if (m_n == 2 || m_n == 3) m_op = {m_op[0], ee_di};
         else if (m_n >= 4 && m_n < 10) m_adr = {m_adr[4:0], ee_di};
         else if (m_n >= 10 && m_n < 26) m_wd = {m_wd[14:0], ee_di};
         m_n++;
      end
   end

   always @(negedge ee_sk) begin
      if (m_op == 2'b10 && m_n >= 10 && m_n < 26) ee_do = mem[m_adr][25 - m_n];
      else ee_do = 1'b0;
   end

   // pin monitor
   bit sk_p = 0, di_p = 0, cs_p = 0, have_rise = 0;
   int since = 0, per_err = 0, di_err = 0, low_cnt = 0, min_gap = 1000, frames_op = 0;

   always @(negedge clk) begin
      if (ee_cs) begin
         if (ee_sk && !sk_p) begin
            if (have_rise && since != 2 * DIV) per_err++;
            have_rise = 1;
            since = 0;
         end
         since++;
         if (ee_sk && sk_p && ee_di !== di_p) di_err++;
      end else have_rise = 0;
      if (ee_cs && !cs_p) begin
         if (frames_op > 0 && low_cnt < min_gap) min_gap = low_cnt;
         frames_op++;
         low_cnt = 0;
      end else if (!ee_cs) low_cnt++;
      if (done) frames_op = 0;
      sk_p = ee_sk; di_p = ee_di; cs_p = ee_cs;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
   endtask

   task automatic peek(input int idx, input int exp, input string req);
      img_idx = 7'(idx);
      #1;
      chk(img_byte == 8'(exp), req, img_byte, exp);
   endtask

   localparam logic [14:0] PROBE [10] = '{
      {7'd0,   8'h01}, {7'd1,   8'h02}, {7'd2,   8'h05}, {7'd3,   8'h06},
      {7'd34,  8'h45}, {7'd35,  8'h46}, {7'd64,  8'h81}, {7'd65,  8'h82},
      {7'd126, 8'hFD}, {7'd127, 8'hFE}
   };

   initial begin
      bit ok;
      int mism;
      repeat (5) @(negedge clk);
      chk({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1 reset outputs",
          {ee_cs, ee_sk, ee_di, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // full load, with a write request thrown in while busy
      load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      repeat (30) @(negedge clk);
      wr_addr = 6'd7; wr_data = 16'h1234; wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      wait_done(ok);
      chk(ok, "R4 load completes", ok, 1);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", {done, busy}, 0);
      chk(m_reads == 64, "R4 read frame count", m_reads, 64);
      chk(m_order_err == 0, "R4 ascending order", m_order_err, 0);
      chk(m_hdr_err == 0 && m_len_err == 0, "R2 frame header/opcode",
          m_hdr_err + m_len_err, 0);
      chk(m_writes == 0 && m_wens == 0, "R10 start ignored while busy",
          m_writes + m_wens, 0);
      chk(mem[7] == pat(6'd7), "R10 memory untouched", mem[7], pat(6'd7));

      for (int k = 0; k < 10; k++)
         peek(int'(PROBE[k][14:8]), int'(PROBE[k][7:0]), "R5 byte placement");

      mism = 0;
      for (int b = 0; b < 128; b++) begin
         logic [15:0] w;
         img_idx = 7'(b);
         #1;
         w = pat(6'(b / 2));
         if (img_byte != ((b % 2) ? w[15:8] : w[7:0])) mism++;
      end
      chk(mism == 0, "R3 full image MSB-first data", mism, 0);

      // single write
      @(negedge clk);
      wr_addr = 6'd5; wr_data = 16'hBEEF; wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      wait_done(ok);
      chk(ok, "R6 write completes", ok, 1);
      chk(m_wens == 1 && m_writes == 1 && m_nowen == 0, "R6 enable before write",
          m_nowen, 0);
      chk(mem[5] == 16'hBEEF, "R6 written word", mem[5], 16'hBEEF);
      peek(10, 8'hEF, "R11 image low byte");
      peek(11, 8'hBE, "R11 image high byte");

      // write at top address
      @(negedge clk);
      wr_addr = 6'd63; wr_data = 16'h0001; wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      wait_done(ok);
      chk(m_wens == 2 && m_writes == 2 && m_nowen == 0, "R6 second enable", m_wens, 2);
      peek(126, 8'h01, "R11 top word low");
      peek(127, 8'h00, "R11 top word high");

      // reload from the device
      @(negedge clk);
      load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      wait_done(ok);
      chk(m_reads == 128 && m_order_err == 0, "R4 second load", m_reads, 128);
      peek(10, 8'hEF, "R5 reloaded low");
      peek(11, 8'hBE, "R5 reloaded high");
      peek(126, 8'h01, "R5 reloaded top");

      chk(min_gap >= 2 * DIV, "R8 cs gap", min_gap, 2 * DIV);
      chk(per_err == 0, "R7 sk period", per_err, 0);
      chk(di_err == 0, "R7 di stable while sk high", di_err, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule